// File: doc/BRIEF.md
# Power-Good Qualified Frequency Strap Capture

This block reads a two-bit frequency-select strap at power-up and keeps it. The strap pins are assumed settled before power-good arrives. The strap pins, the power-good pin and the test-mode pin first pass through a multi-flop synchronizer. A qualifier then declares a valid power-good event once the synchronized power-good level has been asserted for a set number of consecutive samples. At the first valid event the synchronized strap value is stored and a sticky `latched_o` flag is raised. After that, strap and power-good activity has no effect. The one exception is test mode, which lets the qualified event load the strap again.

The stored select value is decoded into a CPU clock-rate code. The rate codes for the PCIe, display/dot and reference clock groups are fixed and do not depend on the select value. All rate codes are unsigned integers in kHz. Frequency synthesis itself is not part of this block.

Top module: `freq_strap_latch`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first capture, `sel_o` is 2'b00 and `latched_o` is 0.
- R2: The first valid power-good event loads the synchronized strap value into `sel_o` and sets `latched_o` to 1.
- R3: Once `latched_o` is 1 and test mode is inactive, changes on `strap_i` leave `sel_o` unchanged.
- R4: Once `latched_o` is 1 and test mode is inactive, deasserting and then reasserting power-good does not reload `sel_o`. `latched_o` stays 1 until reset.
- R5: Power-good counts as valid only when its synchronized level is asserted for 2 consecutive clock samples. An assertion lasting one clock period captures nothing.
- R6: While `test_mode_i` is 1, power-good is qualified and the lock is bypassed, so a new `strap_i` value reaches `sel_o`.
- R7: `cpu_rate_o` decodes `sel_o` as {strap_i[1],strap_i[0]}: 2'b10 gives 100000, 2'b00 gives 133333, 2'b01 gives 166667 and 2'b11 gives 200000 (kHz).
- R8: `pcie_rate_o` is 100000, `dot_rate_o` is 96000 and `ref_rate_o` is 14318 (kHz), whatever the value of `sel_o`.
- R9: When power-good rises with stable straps, `latched_o` is still 0 after the third rising clock edge. It is 1 after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_i | input | 2 | Frequency-select strap pins |
| pwr_good_i | input | 1 | Power-good pin, active high by default |
| test_mode_i | input | 1 | Test-mode pin that bypasses the one-shot lock |
| sel_o | output | 2 | Stored select value |
| cpu_rate_o | output | 18 | Decoded CPU rate in kHz |
| pcie_rate_o | output | 18 | Fixed PCIe rate in kHz |
| dot_rate_o | output | 18 | Fixed display/dot rate in kHz |
| ref_rate_o | output | 18 | Fixed reference rate in kHz |
| latched_o | output | 1 | High once a capture has occurred |

## Verification
The bench sweeps all four strap codes, each from a fresh reset. For each code it checks the decoded CPU rate and the fixed group rates, which separates any mix-up of the decode table. After each capture it drives every other strap code and also drops and reasserts power-good. These patterns tell a true one-shot lock apart from a level-following latch. A single-cycle power-good pulse separates real qualification from plain edge detection. Sampling at the third and fourth edges pins down the latency. A test-mode sequence shows that the lock can be bypassed and that it returns once test mode is cleared.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
   localparam int RATE_W = 18;
   localparam logic [RATE_W-1:0] PCIE_KHZ = 18'd100000;
   localparam logic [RATE_W-1:0] DOT_KHZ  = 18'd96000;
   localparam logic [RATE_W-1:0] REF_KHZ  = 18'd14318;

   function automatic logic [RATE_W-1:0] cpu_khz(input logic [1:0] sel);
      case (sel)
         2'b10:   cpu_khz = 18'd100000;
         2'b00:   cpu_khz = 18'd133333;
         2'b01:   cpu_khz = 18'd166667;
         default: cpu_khz = 18'd200000;
      endcase
   endfunction
endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fsl_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [WIDTH-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '0;
            else        r <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '0;
            else        r <= g_stg[i-1].r;
      end
   end

   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/fsl_qual.sv
module fsl_qual #(
   parameter int QUAL = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pg_s,
   output logic valid
);
   localparam int HW = QUAL - 1;

   if (QUAL < 2) begin : g_bad_qual
      $error("fsl_qual: QUAL must be at least 2");
   end

   logic [HW-1:0] hist;

   if (HW == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) hist <= '0;
         else        hist <= pg_s;
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) hist <= '0;
         else        hist <= {hist[HW-2:0], pg_s};
   end

   assign valid = pg_s & (&hist);

   AST_VALID_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(pg_s)); // R5
endmodule

// File: rtl/fsl_capture.sv
module fsl_capture (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       valid,
   input  logic       test_s,
   input  logic [1:0] strap_s,
   output logic [1:0] sel,
   output logic       latched
);
   logic load;
   assign load = valid & (~latched | test_s);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sel     <= 2'b00;
         latched <= 1'b0;
      end else if (load) begin
         sel     <= strap_s;
         latched <= 1'b1;
      end

   AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!latched && valid) |=> (latched && sel == $past(strap_s))); // R2
   AST_HOLD_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !test_s) |=> $stable(sel)); // R3
   AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      latched |=> latched); // R4
   AST_NO_EVENT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(sel)); // R5
   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !latched |-> sel == 2'b00); // R1
endmodule

// File: rtl/freq_strap_latch.sv
module freq_strap_latch
   import fsl_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int QUAL_SAMPLES  = 2,
   parameter bit PG_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        strap_i,
   input  logic              pwr_good_i,
   input  logic              test_mode_i,
   output logic [1:0]        sel_o,
   output logic [RATE_W-1:0] cpu_rate_o,
   output logic [RATE_W-1:0] pcie_rate_o,
   output logic [RATE_W-1:0] dot_rate_o,
   output logic [RATE_W-1:0] ref_rate_o,
   output logic              latched_o
);
   localparam int BUS_W = 4;

   logic             pg_act;
   logic [BUS_W-1:0] raw_bus, sync_bus;
   logic             valid;

   if (PG_ACTIVE_LOW) begin : g_pg_low
      assign pg_act = ~pwr_good_i;
   end else begin : g_pg_high
      assign pg_act = pwr_good_i;
   end

   assign raw_bus = {test_mode_i, pg_act, strap_i};

   fsl_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
   );

   fsl_qual #(.QUAL(QUAL_SAMPLES)) u_qual (
      .clk(clk), .rst_n(rst_n), .pg_s(sync_bus[2]), .valid(valid)
   );

   fsl_capture u_cap (
      .clk(clk), .rst_n(rst_n), .valid(valid), .test_s(sync_bus[3]),
      .strap_s(sync_bus[1:0]), .sel(sel_o), .latched(latched_o)
   );

   assign cpu_rate_o  = cpu_khz(sel_o);
   assign pcie_rate_o = PCIE_KHZ;
   assign dot_rate_o  = DOT_KHZ;
   assign ref_rate_o  = REF_KHZ;
endmodule

// File: tb/freq_strap_latch_bench.sv
module freq_strap_latch_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  strap = 2'b00;
   logic        pg = 1'b0;
   logic        tm = 1'b0;
   logic [1:0]  sel;
   logic [17:0] cpu, pcie, dot, refr;
   logic        lat;
   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   freq_strap_latch u_freq_strap_latch (
      .clk(clk), .rst_n(rst_n), .strap_i(strap), .pwr_good_i(pg),
      .test_mode_i(tm), .sel_o(sel), .cpu_rate_o(cpu), .pcie_rate_o(pcie),
      .dot_rate_o(dot), .ref_rate_o(refr), .latched_o(lat)
   );

   function automatic logic [17:0] exp_cpu(input logic [1:0] s);
      case (s)
         2'b10:   return 18'd100000;
         2'b00:   return 18'd133333;
         2'b01:   return 18'd166667;
         default: return 18'd200000;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      pg = 1'b0; tm = 1'b0; rst_n = 1'b0;
      cyc(2);
      chk("R1 sel in reset", sel, 2'b00);
      chk("R1 latched in reset", lat, 0);
      rst_n = 1'b1;
      cyc(1);
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cyc(1);
      for (int s = 0; s < 4; s++) begin
         do_reset();
         strap = s[1:0];
         cyc(4);
         chk("R1 sel before capture", sel, 2'b00);
         chk("R1 latched before capture", lat, 0);
         pg = 1'b1;
         cyc(3);
         chk("R9 not latched after 3 edges", lat, 0);
         cyc(1);
         chk("R9 latched after 4 edges", lat, 1);
         chk("R2 captured sel", sel, s[1:0]);
         chk("R7 cpu rate", cpu, exp_cpu(s[1:0]));
         chk("R8 pcie rate", pcie, 100000);
         chk("R8 dot rate", dot, 96000);
         chk("R8 ref rate", refr, 14318);
         for (int o = 1; o < 4; o++) begin
            strap = s[1:0] ^ o[1:0];
            cyc(6);
            chk("R3 strap change ignored", sel, s[1:0]);
            chk("R7 cpu rate held", cpu, exp_cpu(s[1:0]));
         end
         strap = ~s[1:0];
         pg = 1'b0;
         cyc(6);
         pg = 1'b1;
         cyc(6);
         chk("R4 re-asserted power-good ignored", sel, s[1:0]);
         chk("R4 latched sticky", lat, 1);
      end

      do_reset();
      strap = 2'b11;
      cyc(4);
      pg = 1'b1;
      cyc(1);
      pg = 1'b0;
      cyc(8);
      chk("R5 one-cycle pulse no latch", lat, 0);
      chk("R5 one-cycle pulse no sel", sel, 2'b00);
      pg = 1'b1;
      cyc(6);
      chk("R5 held power-good latches", lat, 1);
      chk("R2 sel after held power-good", sel, 2'b11);

      tm = 1'b1;
      strap = 2'b01;
      cyc(6);
      chk("R6 test mode recapture", sel, 2'b01);
      chk("R7 cpu rate in test mode", cpu, exp_cpu(2'b01));
      strap = 2'b10;
      cyc(6);
      chk("R6 test mode second recapture", sel, 2'b10);
      tm = 1'b0;
      cyc(6);
      strap = 2'b00;
      cyc(6);
      chk("R3 lock back after test mode", sel, 2'b10);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule